// File: doc/BRIEF.md
# I2C SCL and Phase Timing Generator

This block times every phase of an I2C master transaction from a fast system clock. A sequencer asks for one phase at a time (START, one data or acknowledge bit, STOP, or repeated START) and the generator drives the open-drain pull-down enables for SCL and SDA. When the phase is over, it pulses a one-cycle completion strobe. All durations are counted in prescaler units. One unit is `DIV+1` clocks. The count for each interval comes from a set of programmable timing words.

Two timing banks are available: fast and high-speed. A transfer starts on the fast bank. The sequencer selects the high-speed bank once the high-speed preamble has been sent. The bank is captured when a phase is accepted. Whenever the generator releases SCL, it waits for the sampled line to read high. It then waits a further fixed filter latency before timing the high phase, so a slave that stretches the clock lengthens the period. With an unstretched line, one bit lasts `(DIV+1)*(L+H+2) + 8 + Fe` clocks. Here `Fe` is the filter cycle field, counted once or twice depending on a build parameter.

Top module: `i2c_scl_timing_gen`

## Requirements
- R1: After reset, both drive enables are low (released), the completion strobe is low and busy is low.
- R2: Every timed interval with count c lasts exactly (c+1)*(DIV+1) clocks. DIV is the 8-bit field at bits [23:16] of timing word 3.
- R3: Phase code 0 (START) keeps SCL and SDA released for (Tsu+1) units, then pulls SDA low for (Thd+1) units, then pulls SCL low. Tsu is bits [31:24] and Thd is bits [23:16] of timing word 1.
- R4: Phase code 1 (BIT) keeps SCL low. SDA keeps its old level for (Dh+1) units after acceptance and then takes the new level (pull-down = not txBit, with txBit captured at acceptance). SCL stays low for max(L+1, Dh+Ds+2) units in total. Dh is bits [7:0] of the shared hold word. Ds is bits [31:24] and L is bits [15:8] of timing word 2.
- R5: After SCL is released, the high phase starts only after the line has read high continuously for 7+Fe clocks plus one synchronizer clock. Fe is the field at configuration bits [18:16], doubled when FILT_TWICE=1. The high phase then lasts (H+1) units, where H is bits [7:0] of timing word 2.
- R6: If a slave holds SCL low for S extra clocks after release, the high phase and all later events of that phase move S clocks later.
- R7: Phase code 2 (STOP) pulls SDA low at acceptance and holds SCL low for (Dh+1) units. It then releases SCL and waits as in R5. After (Tps+1) more units it releases SDA. Tps is bits [15:8] of timing word 1.
- R8: Phase code 3 (repeated START) releases SDA at acceptance and holds SCL low for (Tsr+1) units. It then releases SCL, waits as in R5, and performs the START sequence of R3. Tsr is bits [7:0] of timing word 3.
- R9: hsSel is sampled when a phase is accepted: 1 selects the high-speed words, 0 the fast words. Changing hsSel during a phase has no effect on that phase.
- R10: Only one phase runs at a time. Requests while busy are ignored. phaseDone is high for exactly one clock at completion, in the same cycle that busy drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| phaseReq | input | 1 | Phase request, accepted when idle |
| phaseCode | input | 2 | 0 START, 1 BIT, 2 STOP, 3 repeated START |
| txBit | input | 1 | Bit level for a BIT phase (1 = release SDA) |
| hsSel | input | 1 | Bank select sampled at acceptance (1 = high-speed) |
| sclIn | input | 1 | Sampled level of the SCL line |
| cfgWord | input | 32 | Configuration word, filter count in [18:16] |
| fastWord1 | input | 32 | Fast bank: START setup, START hold, STOP setup |
| fastWord2 | input | 32 | Fast bank: data setup, SCL low, SCL high |
| fastWord3 | input | 32 | Fast bank: prescaler divisor, repeated-START release |
| hsWord1 | input | 32 | High-speed bank, same layout as fastWord1 |
| hsWord2 | input | 32 | High-speed bank, same layout as fastWord2 |
| hsWord3 | input | 32 | High-speed bank, same layout as fastWord3 |
| holdWord | input | 32 | Shared data hold count in [7:0] |
| sclDriveLow | output | 1 | Pull SCL low when 1 |
| sdaDriveLow | output | 1 | Pull SDA low when 1 |
| phaseDone | output | 1 | One-clock completion strobe |
| busy | output | 1 | A phase is in progress |

## Verification
The bench builds the block with FILT_TWICE=1, so the filter field counts twice. Filter values 0 and 7 then give wait latencies of 7 and 21 clocks, the two ends of the range. The fast bank runs with a divisor of 1 and the high-speed bank with a divisor of 2. This shows that unit length follows the selected bank and not a shared prescaler. The high-speed bank is given an SCL low count shorter than hold plus setup, so the stretched-low branch of the BIT timing is reached. The fast bank covers the plain branch. Unused bits of every word are filled with junk to pin the field positions.

// File: rtl/i2c_tmg_pkg.sv
package i2c_tmg_pkg;

  typedef enum logic [1:0] {
    PH_START   = 2'd0,
    PH_BIT     = 2'd1,
    PH_STOP    = 2'd2,
    PH_RESTART = 2'd3
  } phase_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ST_SU, S_ST_HD,
    S_BIT_LO, S_BIT_WAIT, S_BIT_HI,
    S_SP_LO, S_SP_WAIT, S_SP_SU,
    S_RS_LO, S_RS_WAIT
  } state_e;

  // Counts of the active bank, each an 8-bit field
  typedef struct packed {
    logic [7:0] startSu;
    logic [7:0] startHd;
    logic [7:0] stopSu;
    logic [7:0] dataSu;
    logic [7:0] sclLo;
    logic [7:0] sclHi;
    logic [7:0] preDiv;
    logic [7:0] srRel;
    logic [7:0] dataHd;
  } tmg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic stageClr;
    logic bankLatch;
  } dpCtl_t;

  // Status from datapath to control
  typedef struct packed {
    logic       tickLast;
    logic [9:0] tickCnt;
    logic       lineReady;
  } dpStat_t;

endpackage

// File: rtl/i2c_tmg_dp.sv
module i2c_tmg_dp
  import i2c_tmg_pkg::*;
#(
  parameter bit FILT_TWICE = 1'b0,
  parameter int LAT_BASE   = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpCtl_t      ctl,
  input  logic        hsSel,
  input  logic        sclIn,
  input  logic [31:0] cfgWord,
  input  logic [31:0] fastWord1,
  input  logic [31:0] fastWord2,
  input  logic [31:0] fastWord3,
  input  logic [31:0] hsWord1,
  input  logic [31:0] hsWord2,
  input  logic [31:0] hsWord3,
  input  logic [31:0] holdWord,
  output tmg_t        tmg,
  output dpStat_t     stat
);

  localparam int CNT_W = 10;
  localparam int LAT_W = 5;

  logic             bankHs;
  logic [7:0]       cyc;
  logic [CNT_W-1:0] tickCnt;
  logic [LAT_W-1:0] hiCnt;
  logic             sclSync;
  logic [2:0]       filtF;
  logic [3:0]       fe;
  logic [LAT_W-1:0] latM1;
  logic [31:0]      w1, w2, w3;
  logic             unusedBits;

  assign filtF = cfgWord[18:16];

  generate
    if (FILT_TWICE) begin : g_twice
      assign fe = {filtF, 1'b0};
    end else begin : g_once
      assign fe = {1'b0, filtF};
    end
  endgenerate

  assign latM1 = LAT_W'(LAT_BASE) + {1'b0, fe} - 5'd1;

  assign w1 = bankHs ? hsWord1 : fastWord1;
  assign w2 = bankHs ? hsWord2 : fastWord2;
  assign w3 = bankHs ? hsWord3 : fastWord3;

  always_comb begin
    tmg.startSu = w1[31:24];
    tmg.startHd = w1[23:16];
    tmg.stopSu  = w1[15:8];
    tmg.dataSu  = w2[31:24];
    tmg.sclLo   = w2[15:8];
    tmg.sclHi   = w2[7:0];
    tmg.preDiv  = w3[23:16];
    tmg.srRel   = w3[7:0];
    tmg.dataHd  = holdWord[7:0];
  end

  assign unusedBits = ^{w1[7:0], w2[23:16], w3[31:24], w3[15:8],
                        holdWord[31:8], cfgWord[31:19], cfgWord[15:0]};

  assign stat.tickLast  = (cyc == tmg.preDiv);
  assign stat.tickCnt   = tickCnt;
  assign stat.lineReady = sclSync && (hiCnt == latM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankHs  <= 1'b0;
      cyc     <= '0;
      tickCnt <= '0;
      hiCnt   <= '0;
      sclSync <= 1'b0;
    end else begin
      sclSync <= sclIn;
      if (ctl.bankLatch) bankHs <= hsSel;
      if (ctl.stageClr) begin
        cyc     <= '0;
        tickCnt <= '0;
        hiCnt   <= '0;
      end else begin
        if (stat.tickLast) begin
          cyc     <= '0;
          tickCnt <= tickCnt + 1'b1;
        end else begin
          cyc <= cyc + 1'b1;
        end
        if (!sclSync)            hiCnt <= '0;
        else if (hiCnt != '1)    hiCnt <= hiCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2c_tmg_ctrl.sv
module i2c_tmg_ctrl
  import i2c_tmg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       phaseReq,
  input  logic [1:0] phaseCode,
  input  logic       txBit,
  input  tmg_t       tmg,
  input  dpStat_t    stat,
  output dpCtl_t     ctl,
  output logic       sclDriveLow,
  output logic       sdaDriveLow,
  output logic       phaseDone,
  output logic       busy
);

  state_e     state, nextState;
  phase_e     code;
  logic       accept, stEnd, sdaUpd, bitVal;
  logic [9:0] loNeed;

  function automatic logic endOf(input dpStat_t s, input logic [7:0] c);
    return s.tickLast && (s.tickCnt == {2'b00, c});
  endfunction

  assign code   = phase_e'(phaseCode);
  assign busy   = (state != S_IDLE);
  assign accept = (state == S_IDLE) && phaseReq;

  always_comb begin
    loNeed = {2'b00, tmg.dataHd} + {2'b00, tmg.dataSu} + 10'd1;
    if ({2'b00, tmg.sclLo} > loNeed) loNeed = {2'b00, tmg.sclLo};
  end

  assign sdaUpd = endOf(stat, tmg.dataHd);

  always_comb begin
    stEnd = 1'b0;
    case (state)
      S_ST_SU:    stEnd = endOf(stat, tmg.startSu);
      S_ST_HD:    stEnd = endOf(stat, tmg.startHd);
      S_BIT_LO:   stEnd = stat.tickLast && (stat.tickCnt == loNeed);
      S_BIT_HI:   stEnd = endOf(stat, tmg.sclHi);
      S_SP_LO:    stEnd = endOf(stat, tmg.dataHd);
      S_SP_SU:    stEnd = endOf(stat, tmg.stopSu);
      S_RS_LO:    stEnd = endOf(stat, tmg.srRel);
      S_BIT_WAIT, S_SP_WAIT, S_RS_WAIT: stEnd = stat.lineReady;
      default:    stEnd = 1'b0;
    endcase
  end

  always_comb begin
    nextState = state;
    if (accept) begin
      case (code)
        PH_START: nextState = S_ST_SU;
        PH_BIT:   nextState = S_BIT_LO;
        PH_STOP:  nextState = S_SP_LO;
        default:  nextState = S_RS_LO;
      endcase
    end else if (stEnd) begin
      case (state)
        S_ST_SU:    nextState = S_ST_HD;
        S_BIT_LO:   nextState = S_BIT_WAIT;
        S_BIT_WAIT: nextState = S_BIT_HI;
        S_SP_LO:    nextState = S_SP_WAIT;
        S_SP_WAIT:  nextState = S_SP_SU;
        S_RS_LO:    nextState = S_RS_WAIT;
        S_RS_WAIT:  nextState = S_ST_SU;
        default:    nextState = S_IDLE;
      endcase
    end
  end

  assign ctl.stageClr  = accept || stEnd;
  assign ctl.bankLatch = accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      sclDriveLow <= 1'b0;
      sdaDriveLow <= 1'b0;
      phaseDone   <= 1'b0;
      bitVal      <= 1'b0;
    end else begin
      state     <= nextState;
      phaseDone <= 1'b0;
      if (accept) begin
        bitVal <= txBit;
        if (code == PH_STOP)         sdaDriveLow <= 1'b1;
        else if (code == PH_RESTART) sdaDriveLow <= 1'b0;
      end
      if (state == S_BIT_LO && sdaUpd) sdaDriveLow <= !bitVal;
      if (stEnd) begin
        case (state)
          S_ST_SU: sdaDriveLow <= 1'b1;
          S_ST_HD, S_BIT_HI: begin
            sclDriveLow <= 1'b1;
            phaseDone   <= 1'b1;
          end
          S_SP_SU: begin
            sdaDriveLow <= 1'b0;
            phaseDone   <= 1'b1;
          end
          S_BIT_LO, S_SP_LO, S_RS_LO: sclDriveLow <= 1'b0;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_scl_timing_gen.sv
module i2c_scl_timing_gen
  import i2c_tmg_pkg::*;
#(
  parameter bit FILT_TWICE = 1'b0,
  parameter int LAT_BASE   = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        phaseReq,
  input  logic [1:0]  phaseCode,
  input  logic        txBit,
  input  logic        hsSel,
  input  logic        sclIn,
  input  logic [31:0] cfgWord,
  input  logic [31:0] fastWord1,
  input  logic [31:0] fastWord2,
  input  logic [31:0] fastWord3,
  input  logic [31:0] hsWord1,
  input  logic [31:0] hsWord2,
  input  logic [31:0] hsWord3,
  input  logic [31:0] holdWord,
  output logic        sclDriveLow,
  output logic        sdaDriveLow,
  output logic        phaseDone,
  output logic        busy
);

  dpCtl_t  ctl;
  dpStat_t stat;
  tmg_t    tmg;

  i2c_tmg_dp #(.FILT_TWICE(FILT_TWICE), .LAT_BASE(LAT_BASE)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .hsSel(hsSel), .sclIn(sclIn),
    .cfgWord(cfgWord), .fastWord1(fastWord1), .fastWord2(fastWord2),
    .fastWord3(fastWord3), .hsWord1(hsWord1), .hsWord2(hsWord2),
    .hsWord3(hsWord3), .holdWord(holdWord), .tmg(tmg), .stat(stat)
  );

  i2c_tmg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .phaseReq(phaseReq), .phaseCode(phaseCode),
    .txBit(txBit), .tmg(tmg), .stat(stat), .ctl(ctl),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .phaseDone(phaseDone), .busy(busy)
  );

endmodule

// File: rtl/i2c_scl_timing_gen_chk.sv
module i2c_scl_timing_gen_chk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sclDriveLow,
  input logic phaseDone,
  input logic busy
);

  // R10: completion strobe lasts one clock
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    phaseDone |=> !phaseDone);

  // R10: completion coincides with return to idle
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    phaseDone |-> !busy);

  // R10: busy only ends through a completion
  a_r10_busy_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> phaseDone);

  // R6: while released SCL still reads low, it is not pulled low again
  a_r6_no_pull_line_low: assert property (@(posedge clk) disable iff (!rstN)
    (!sclDriveLow && !sclIn) |=> !sclDriveLow);

endmodule

bind i2c_scl_timing_gen i2c_scl_timing_gen_chk chk_i (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sclDriveLow(sclDriveLow),
  .phaseDone(phaseDone), .busy(busy)
);

// File: tb/i2c_scl_timing_gen_tb_top.sv
module i2c_scl_timing_gen_tb_top;

  localparam int FTW = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        phaseReq = 1'b0;
  logic [1:0]  phaseCode = 2'd0;
  logic        txBit = 1'b0;
  logic        hsSel = 1'b0;
  logic        sclIn;
  logic [31:0] cfgWord, fastWord1, fastWord2, fastWord3;
  logic [31:0] hsWord1, hsWord2, hsWord3, holdWord;
  logic        sclDriveLow, sdaDriveLow, phaseDone, busy;

  always #2 clk = ~clk;

  i2c_scl_timing_gen #(.FILT_TWICE(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .phaseReq(phaseReq), .phaseCode(phaseCode),
    .txBit(txBit), .hsSel(hsSel), .sclIn(sclIn), .cfgWord(cfgWord),
    .fastWord1(fastWord1), .fastWord2(fastWord2), .fastWord3(fastWord3),
    .hsWord1(hsWord1), .hsWord2(hsWord2), .hsWord3(hsWord3),
    .holdWord(holdWord), .sclDriveLow(sclDriveLow),
    .sdaDriveLow(sdaDriveLow), .phaseDone(phaseDone), .busy(busy)
  );

  // Bus model: released SCL rises after stretchAmt extra clocks
  int stretchAmt = 0;
  int stretchCnt = 0;
  always @(posedge clk) begin
    if (sclDriveLow) stretchCnt <= stretchAmt;
    else if (stretchCnt > 0) stretchCnt <= stretchCnt - 1;
  end
  assign sclIn = !sclDriveLow && (stretchCnt == 0);

  // Timing fields, index 0 fast, 1 high-speed
  int su[2], hd[2], ssu[2], dsu[2], lo[2], hi[2], dv[2], sr[2];
  int holdCnt, filtF;

  task automatic applyCfg();
    fastWord1 = {8'(su[0]), 8'(hd[0]), 8'(ssu[0]), 8'h5A};
    fastWord2 = {8'(dsu[0]), 8'hC3, 8'(lo[0]), 8'(hi[0])};
    fastWord3 = {8'hE7, 8'(dv[0]), 8'h99, 8'(sr[0])};
    hsWord1   = {8'(su[1]), 8'(hd[1]), 8'(ssu[1]), 8'hA5};
    hsWord2   = {8'(dsu[1]), 8'h3C, 8'(lo[1]), 8'(hi[1])};
    hsWord3   = {8'h7E, 8'(dv[1]), 8'h66, 8'(sr[1])};
    holdWord  = {24'hF0F0F0, 8'(holdCnt)};
    cfgWord   = {13'h1ABC, 3'(filtF), 16'hBEEF};
  endtask

  typedef struct {
    bit    scl;
    bit    sda;
    bit    done;
    bit    bsy;
    string tag;
  } exp_t;

  exp_t  expQ[$];
  exp_t  e;
  bit    curScl = 1'b0, curSda = 1'b0;
  string tagOv = "";
  string idleTag = "R1";
  int    nChecks = 0, nFails = 0;
  bit    running = 1'b0;

  task automatic push(int n, string tag);
    exp_t x;
    for (int i = 0; i < n; i++) begin
      x.scl = curScl; x.sda = curSda; x.done = 1'b0; x.bsy = 1'b1;
      x.tag = (tagOv != "") ? tagOv : tag;
      expQ.push_back(x);
    end
  endtask

  task automatic pushDone();
    exp_t x;
    x.scl = curScl; x.sda = curSda; x.done = 1'b1; x.bsy = 1'b0; x.tag = "R10";
    expQ.push_back(x);
  endtask

  // Compare every clock against the reference model
  always @(negedge clk) begin
    if (running) begin
      if (expQ.size() > 0) e = expQ.pop_front();
      else begin
        e.scl = curScl; e.sda = curSda; e.done = 1'b0; e.bsy = 1'b0; e.tag = idleTag;
      end
      nChecks++;
      if ({sclDriveLow, sdaDriveLow, phaseDone, busy} !== {e.scl, e.sda, e.done, e.bsy}) begin
        nFails++;
        $display("FAIL %s t=%0t scl/sda/done/busy actual=%b%b%b%b expected=%b%b%b%b",
                 e.tag, $time, sclDriveLow, sdaDriveLow, phaseDone, busy,
                 e.scl, e.sda, e.done, e.bsy);
      end
    end
  end

  task automatic runPhase(int code, bit bv, bit hs, int s, bit disturb);
    int b, u, w, m;
    b = hs ? 1 : 0;
    u = dv[b] + 1;
    w = 7 + (FTW ? 2 * filtF : filtF) + 1 + s;
    stretchAmt = s;
    @(negedge clk);
    phaseReq = 1'b1; phaseCode = 2'(code); txBit = bv; hsSel = hs;
    @(posedge clk); #1;
    phaseReq = 1'b0;
    tagOv = disturb ? "R9" : "";
    case (code)
      0: begin
        push((su[b] + 1) * u, "R2");
        curSda = 1'b1; push((hd[b] + 1) * u, "R3");
        curScl = 1'b1; pushDone();
      end
      1: begin
        push((holdCnt + 1) * u, "R4");
        curSda = !bv;
        m = lo[b] + 1;
        if (holdCnt + dsu[b] + 2 > m) m = holdCnt + dsu[b] + 2;
        push((m - holdCnt - 1) * u, "R4");
        curScl = 1'b0; push(w, (s > 0) ? "R6" : "R5");
        push((hi[b] + 1) * u, "R5");
        curScl = 1'b1; pushDone();
      end
      2: begin
        curSda = 1'b1; push((holdCnt + 1) * u, "R7");
        curScl = 1'b0; push(w, (s > 0) ? "R6" : "R7");
        push((ssu[b] + 1) * u, "R7");
        curSda = 1'b0; pushDone();
      end
      default: begin
        curSda = 1'b0; push((sr[b] + 1) * u, "R8");
        curScl = 1'b0; push(w, (s > 0) ? "R6" : "R8");
        push((su[b] + 1) * u, "R8");
        curSda = 1'b1; push((hd[b] + 1) * u, "R8");
        curScl = 1'b1; pushDone();
      end
    endcase
    tagOv = "";
    idleTag = "R10";
    if (disturb) begin
      repeat (3) @(negedge clk);
      phaseReq = 1'b1; phaseCode = 2'(3 - code); hsSel = !hs;
      @(negedge clk);
      phaseReq = 1'b0;
    end
    while (expQ.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      nFails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    su  = '{4, 2}; hd = '{3, 1}; ssu = '{5, 2}; dsu = '{3, 1};
    lo  = '{9, 2}; hi = '{6, 3}; dv  = '{1, 2}; sr  = '{4, 1};
    holdCnt = 2; filtF = 0;
    applyCfg();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    running = 1'b1;
    repeat (4) @(negedge clk);                 // R1 idle checks
    // Fast bank, filter 0
    runPhase(0, 1'b0, 1'b0, 0, 1'b0);          // R2 R3 START
    runPhase(1, 1'b1, 1'b0, 0, 1'b0);          // R4 R5 BIT 1
    runPhase(1, 1'b0, 1'b0, 0, 1'b0);          // R4 BIT 0
    runPhase(1, 1'b0, 1'b0, 5, 1'b0);          // R6 stretched
    runPhase(3, 1'b0, 1'b0, 0, 1'b0);          // R8 repeated START
    runPhase(1, 1'b1, 1'b0, 0, 1'b1);          // R9 R10 disturbed
    runPhase(2, 1'b0, 1'b0, 0, 1'b0);          // R7 STOP
    // High-speed bank, filter 7, longer hold
    filtF = 7; holdCnt = 3;
    applyCfg();
    runPhase(0, 1'b0, 1'b0, 0, 1'b0);          // START on fast bank
    runPhase(1, 1'b0, 1'b1, 0, 1'b0);          // R4 low stretched by hold+setup
    runPhase(1, 1'b1, 1'b1, 3, 1'b1);          // R9 bank held, R6
    runPhase(3, 1'b0, 1'b1, 0, 1'b0);          // R8 on high-speed bank
    runPhase(1, 1'b1, 1'b1, 0, 1'b0);
    runPhase(2, 1'b0, 1'b1, 2, 1'b0);          // R7 with stretch
    repeat (4) @(negedge clk);
    running = 1'b0;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule